// File: doc/BRIEF.md
# Control Register Access Unit

This unit keeps the processor's control registers and serves register-move instructions. A single index selects the register. A write strobe stores the data at that index. A read strobe returns the selected register one cycle later. A third strobe performs the legacy status-word load, which replaces only the low nibble of register 0.

Writes to registers 0, 3 and 4 each raise their own one-cycle update pulse. Paging and mode-control logic downstream uses these pulses to react to the change.

Index 8 holds the task priority and is handled differently. It is not stored in the register array. A mode input selects virtual-interrupt operation:
- When the mode is off, reads of index 8 come from an external priority port, and writes are forwarded to that port.
- When the mode is on, reads of index 8 return a local 4-bit shadow, and writes are not forwarded.
- In either mode, every write to index 8 refreshes the shadow.

Top module: `ctrlreg_unit`

## Requirements
- R1: After reset, every stored register and the 4-bit shadow read as zero, and all pulse and valid outputs are low.
- R2: A write to any index other than 8 stores the full data word. A read of that index returns it, with `rd_valid_o` high exactly one cycle after `rd_i`.
- R3: A write to index 0, 3 or 4 raises `upd_cr0_o`, `upd_cr3_o` or `upd_cr4_o` respectively for exactly one cycle, starting the cycle after the write. Writes to other indices raise no pulse.
- R4: A status-word load sets register 0 bits [3:1] from operand bits [3:1], leaves bits [XLEN-1:4] unchanged, and raises `upd_cr0_o`.
- R5: During a status-word load, register 0 bit 0 becomes the OR of its old value and operand bit 0, so the load can set it but never clear it. A plain write to index 0 may clear it.
- R6: With `vintr_i` low, a read of index 8 returns `tpr_ext_i` as sampled at the read edge.
- R7: With `vintr_i` high, a read of index 8 returns the shadow, zero-extended.
- R8: A write to index 8 with `vintr_i` low pulses `tpr_wr_o` for one cycle, with the full data word on `tpr_wdata_o`. With `vintr_i` high, `tpr_wr_o` stays low.
- R9: Every write to index 8 stores data bits [3:0] in the shadow, whatever the state of `vintr_i`.
- R10: When a write and a status-word load arrive in the same cycle, the write takes effect and the load is dropped. A read in the same cycle as a write returns the value held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| idx_i | input | IDX_W | Register index for read and write |
| wdata_i | input | XLEN | Write data, also the status-word operand |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| lmsw_i | input | 1 | Status-word load strobe |
| vintr_i | input | 1 | Virtual-interrupt mode for index 8 |
| tpr_ext_i | input | XLEN | External task-priority value |
| rd_data_o | output | XLEN | Registered read data |
| rd_valid_o | output | 1 | Read data valid, one cycle after `rd_i` |
| upd_cr0_o | output | 1 | Register 0 changed |
| upd_cr3_o | output | 1 | Register 3 changed |
| upd_cr4_o | output | 1 | Register 4 changed |
| tpr_wr_o | output | 1 | Write pulse to external priority port |
| tpr_wdata_o | output | XLEN | Data for external priority port |

## Verification
The bench targets the following corner cases, each of which a faulty design would fail in a visible way:
- **Sticky bit 0.** A status-word load with operand bit 0 clear is applied to a register 0 whose bit 0 is set. A design that copied the bit instead of OR-ing it would drop bit 0.
- **Upper bits of register 0.** A status-word load uses an operand whose upper bits are all ones. A design that took more than the nibble would corrupt the upper bits of register 0.
- **Routing of index 8.** Writes and reads of index 8 alternate between the two modes. A design that refreshed the shadow only in virtual mode would return stale data, and one that forwarded writes in both modes would pulse the external port when it should not.
- **Same-cycle collisions.** A write is issued together with a status-word load, and a read together with a write. A wrong precedence would show the load result, and a read that bypasses the write would show the new value one cycle early.

// File: rtl/ctrlreg_pkg.sv
package ctrlreg_pkg;

  localparam int unsigned IDX_CR0  = 0;
  localparam int unsigned IDX_CR3  = 3;
  localparam int unsigned IDX_CR4  = 4;
  localparam int unsigned IDX_PRIO = 8;
  localparam int unsigned NIB_W    = 4;

  typedef struct packed {
    logic cr0;
    logic cr3;
    logic cr4;
  } upd_t;

  // Status-word merge on the low nibble: bits [3:1] come from the operand,
  // bit 0 can only be set.
  function automatic logic [NIB_W-1:0] msw_merge(input logic [NIB_W-1:0] cur,
                                                 input logic [NIB_W-1:0] op);
    return {op[NIB_W-1:1], cur[0] | op[0]};
  endfunction

endpackage

// File: rtl/ctrlreg_file.sv
module ctrlreg_file
  import ctrlreg_pkg::*;
#(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned IDX_W = 4
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_i,
  input  logic                             lmsw_i,
  input  logic [IDX_W-1:0]                 idx_i,
  input  logic [XLEN-1:0]                  wdata_i,
  output logic [(1<<IDX_W)-1:0][XLEN-1:0]  regs_o,
  output upd_t                             upd_o
);
  localparam int unsigned NREG = 1 << IDX_W;

  logic [NREG-1:0] we_vec;
  logic            msw_fire;
  upd_t            upd_d;
  upd_t            upd_q;

  // The load loses to a write in the same cycle.
  assign msw_fire = lmsw_i && !wr_i;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    assign we_vec[i] = wr_i && (idx_i == IDX_W'(i));
    if (i == IDX_PRIO) begin : g_hole
      assign regs_o[i] = '0;
    end else if (i == IDX_CR0) begin : g_cr0
      logic [XLEN-1:0] q;
      always_ff @(posedge clk) begin
        if (!rst_n)
          q <= '0;
        else if (we_vec[i])
          q <= wdata_i;
        else if (msw_fire)
          q <= {q[XLEN-1:NIB_W], msw_merge(q[NIB_W-1:0], wdata_i[NIB_W-1:0])};
      end
      assign regs_o[i] = q;
    end else begin : g_plain
      logic [XLEN-1:0] q;
      always_ff @(posedge clk) begin
        if (!rst_n)
          q <= '0;
        else if (we_vec[i])
          q <= wdata_i;
      end
      assign regs_o[i] = q;
    end
  end

  always_comb begin
    upd_d.cr0 = we_vec[IDX_CR0] || msw_fire;
    upd_d.cr3 = we_vec[IDX_CR3];
    upd_d.cr4 = we_vec[IDX_CR4];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      upd_q <= '0;
    else
      upd_q <= upd_d;
  end

  assign upd_o = upd_q;

  // R3
  cr3_pulse_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_q.cr3 |-> $past(wr_i && idx_i == IDX_W'(IDX_CR3)));
  // R3
  cr4_pulse_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_q.cr4 |-> $past(wr_i && idx_i == IDX_W'(IDX_CR4)));
  // R5
  pe_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(msw_fire) && $past(regs_o[IDX_CR0][0])) |-> regs_o[IDX_CR0][0]);
  // R4
  msw_high_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msw_fire |=> regs_o[IDX_CR0][XLEN-1:NIB_W] == $past(regs_o[IDX_CR0][XLEN-1:NIB_W]));
  // R4
  msw_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msw_fire |=> upd_q.cr0);

endmodule

// File: rtl/ctrlreg_prio.sv
module ctrlreg_prio
  import ctrlreg_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            vintr_i,
  input  logic            wr8_i,
  input  logic [XLEN-1:0] wdata_i,
  input  logic [XLEN-1:0] tpr_ext_i,
  output logic [XLEN-1:0] rd_val_o,
  output logic            tpr_wr_o,
  output logic [XLEN-1:0] tpr_wdata_o
);
  logic [NIB_W-1:0] vtpr_q;
  logic             fwd_fire;
  logic             fwd_q;
  logic [XLEN-1:0]  fwd_data_q;

  assign fwd_fire = wr8_i && !vintr_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vtpr_q     <= '0;
      fwd_q      <= 1'b0;
      fwd_data_q <= '0;
    end else begin
      fwd_q <= fwd_fire;
      if (wr8_i)
        vtpr_q <= wdata_i[NIB_W-1:0];
      if (fwd_fire)
        fwd_data_q <= wdata_i;
    end
  end

  assign rd_val_o    = vintr_i ? {{(XLEN-NIB_W){1'b0}}, vtpr_q} : tpr_ext_i;
  assign tpr_wr_o    = fwd_q;
  assign tpr_wdata_o = fwd_data_q;

  // R8
  tpr_fwd_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tpr_wr_o |-> $past(wr8_i && !vintr_i));
  // R9
  shadow_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr8_i |=> vtpr_q == $past(wdata_i[NIB_W-1:0]));

endmodule

// File: rtl/ctrlreg_unit.sv
module ctrlreg_unit
  import ctrlreg_pkg::*;
#(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [XLEN-1:0]  wdata_i,
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic             lmsw_i,
  input  logic             vintr_i,
  input  logic [XLEN-1:0]  tpr_ext_i,
  output logic [XLEN-1:0]  rd_data_o,
  output logic             rd_valid_o,
  output logic             upd_cr0_o,
  output logic             upd_cr3_o,
  output logic             upd_cr4_o,
  output logic             tpr_wr_o,
  output logic [XLEN-1:0]  tpr_wdata_o
);
  localparam int unsigned NREG = 1 << IDX_W;

  logic [NREG-1:0][XLEN-1:0] regs;
  upd_t                      upd;
  logic                      sel_prio;
  logic                      wr8;
  logic [XLEN-1:0]           prio_val;
  logic [XLEN-1:0]           rd_sel;
  logic [XLEN-1:0]           rd_q;
  logic                      rv_q;

  assign sel_prio = (idx_i == IDX_W'(IDX_PRIO));
  assign wr8      = wr_i && sel_prio;

  ctrlreg_file #(.XLEN(XLEN), .IDX_W(IDX_W)) file_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (wr_i),
    .lmsw_i  (lmsw_i),
    .idx_i   (idx_i),
    .wdata_i (wdata_i),
    .regs_o  (regs),
    .upd_o   (upd)
  );

  ctrlreg_prio #(.XLEN(XLEN)) prio_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .vintr_i     (vintr_i),
    .wr8_i       (wr8),
    .wdata_i     (wdata_i),
    .tpr_ext_i   (tpr_ext_i),
    .rd_val_o    (prio_val),
    .tpr_wr_o    (tpr_wr_o),
    .tpr_wdata_o (tpr_wdata_o)
  );

  assign rd_sel = sel_prio ? prio_val : regs[idx_i];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_q <= '0;
      rv_q <= 1'b0;
    end else begin
      rv_q <= rd_i;
      if (rd_i)
        rd_q <= rd_sel;
    end
  end

  assign rd_data_o  = rd_q;
  assign rd_valid_o = rv_q;
  assign upd_cr0_o  = upd.cr0;
  assign upd_cr3_o  = upd.cr3;
  assign upd_cr4_o  = upd.cr4;

  // R2
  rd_valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_i |=> rd_valid_o);
  // R2
  rd_valid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_o |-> $past(rd_i));
  // R3
  cr0_pulse_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_cr0_o |-> $past((wr_i && idx_i == IDX_W'(IDX_CR0)) || lmsw_i));

endmodule

// File: tb/ctrlreg_unit_tb_top.sv
`timescale 1ns/1ps
module ctrlreg_unit_tb_top;
  localparam int XLEN  = 32;
  localparam int IDX_W = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [IDX_W-1:0] idx_i = '0;
  logic [XLEN-1:0]  wdata_i = '0;
  logic             wr_i = 1'b0;
  logic             rd_i = 1'b0;
  logic             lmsw_i = 1'b0;
  logic             vintr_i = 1'b0;
  logic [XLEN-1:0]  tpr_ext_i = '0;
  logic [XLEN-1:0]  rd_data_o;
  logic             rd_valid_o;
  logic             upd_cr0_o, upd_cr3_o, upd_cr4_o;
  logic             tpr_wr_o;
  logic [XLEN-1:0]  tpr_wdata_o;

  int checks = 0;
  int fails  = 0;

  logic [XLEN-1:0] s_rdata, s_twd;
  logic            s_rv, s_u0, s_u3, s_u4, s_tw;

  always #2.5 clk = ~clk;

  ctrlreg_unit #(.XLEN(XLEN), .IDX_W(IDX_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .idx_i(idx_i), .wdata_i(wdata_i),
    .wr_i(wr_i), .rd_i(rd_i), .lmsw_i(lmsw_i), .vintr_i(vintr_i),
    .tpr_ext_i(tpr_ext_i), .rd_data_o(rd_data_o), .rd_valid_o(rd_valid_o),
    .upd_cr0_o(upd_cr0_o), .upd_cr3_o(upd_cr3_o), .upd_cr4_o(upd_cr4_o),
    .tpr_wr_o(tpr_wr_o), .tpr_wdata_o(tpr_wdata_o)
  );

  task automatic check(input string req, input logic [XLEN-1:0] act,
                       input logic [XLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One operation: drive at negedge, sample 1 ns after the capturing edge.
  task automatic step(input logic w, input logic r, input logic l,
                      input logic [IDX_W-1:0] ix, input logic [XLEN-1:0] d);
    @(negedge clk);
    wr_i = w; rd_i = r; lmsw_i = l; idx_i = ix; wdata_i = d;
    @(posedge clk);
    #1;
    s_rdata = rd_data_o; s_rv = rd_valid_o; s_u0 = upd_cr0_o;
    s_u3 = upd_cr3_o; s_u4 = upd_cr4_o; s_tw = tpr_wr_o; s_twd = tpr_wdata_o;
    wr_i = 1'b0; rd_i = 1'b0; lmsw_i = 1'b0;
  endtask

  task automatic idle();
    step(1'b0, 1'b0, 1'b0, '0, '0);
  endtask

  task automatic rd_chk(input string req, input logic [IDX_W-1:0] ix,
                        input logic [XLEN-1:0] exp);
    step(1'b0, 1'b1, 1'b0, ix, '0);
    check(req, {31'b0, s_rv}, 32'd1);
    check(req, s_rdata, exp);
  endtask

  task automatic t_reset();
    check("R1 valid", {31'b0, rd_valid_o}, 0);
    check("R1 pulses", {27'b0, upd_cr0_o, upd_cr3_o, upd_cr4_o, tpr_wr_o, 1'b0}, 0);
    rd_chk("R1 cr0", 4'd0, 0);
    rd_chk("R1 cr3", 4'd3, 0);
    rd_chk("R1 cr2", 4'd2, 0);
    vintr_i = 1'b1;
    rd_chk("R1 shadow", 4'd8, 0);
    vintr_i = 1'b0;
    idle();
    check("R2 valid drops", {31'b0, s_rv}, 0);
  endtask

  task automatic t_store();
    step(1'b1, 1'b0, 1'b0, 4'd2, 32'hA5A5_1234);
    check("R3 no pulse idx2", {29'b0, s_u0, s_u3, s_u4}, 0);
    step(1'b1, 1'b0, 1'b0, 4'd15, 32'h0BAD_F00D);
    rd_chk("R2 idx2", 4'd2, 32'hA5A5_1234);
    rd_chk("R2 idx15", 4'd15, 32'h0BAD_F00D);
  endtask

  task automatic t_pulses();
    step(1'b1, 1'b0, 1'b0, 4'd3, 32'h0000_3000);
    check("R3 cr3 pulse", {29'b0, s_u0, s_u3, s_u4}, 32'b010);
    idle();
    check("R3 cr3 one cycle", {31'b0, s_u3}, 0);
    step(1'b1, 1'b0, 1'b0, 4'd4, 32'h0000_0020);
    check("R3 cr4 pulse", {29'b0, s_u0, s_u3, s_u4}, 32'b001);
    step(1'b1, 1'b0, 1'b0, 4'd0, 32'hDEAD_BEE0);
    check("R3 cr0 pulse", {29'b0, s_u0, s_u3, s_u4}, 32'b100);
    idle();
    check("R3 cr0 one cycle", {31'b0, s_u0}, 0);
    rd_chk("R2 cr3", 4'd3, 32'h0000_3000);
    rd_chk("R2 cr4", 4'd4, 32'h0000_0020);
  endtask

  task automatic t_msw();
    logic [XLEN-1:0] m;
    m = 32'hDEAD_BEE0;
    step(1'b0, 1'b0, 1'b1, 4'd0, 32'hFFFF_FFF7);
    check("R4 pulse", {31'b0, s_u0}, 1);
    m = (m & ~32'hE) | (32'hFFFF_FFF7 & 32'hF);
    rd_chk("R4 merge", 4'd0, m);
    step(1'b0, 1'b0, 1'b1, 4'd0, 32'h0000_0000);
    m = (m & ~32'hE) | 32'h0;
    rd_chk("R5 bit0 kept", 4'd0, m);
    step(1'b1, 1'b0, 1'b0, 4'd0, 32'h0000_0000);
    rd_chk("R5 write clears", 4'd0, 0);
    step(1'b0, 1'b0, 1'b1, 4'd3, 32'h0000_0009);
    rd_chk("R5 load sets", 4'd0, 32'h0000_0009);
  endtask

  task automatic t_prio();
    vintr_i = 1'b0;
    tpr_ext_i = 32'h0000_00C3;
    rd_chk("R6 ext read", 4'd8, 32'h0000_00C3);
    step(1'b1, 1'b0, 1'b0, 4'd8, 32'h1234_567B);
    check("R8 fwd pulse", {31'b0, s_tw}, 1);
    check("R8 fwd data", s_twd, 32'h1234_567B);
    idle();
    check("R8 one cycle", {31'b0, s_tw}, 0);
    vintr_i = 1'b1;
    rd_chk("R9 shadow off-mode", 4'd8, 32'h0000_000B);
    step(1'b1, 1'b0, 1'b0, 4'd8, 32'hFFFF_FF06);
    check("R8 no fwd", {31'b0, s_tw}, 0);
    idle();
    check("R8 no fwd later", {31'b0, s_tw}, 0);
    rd_chk("R7 shadow read", 4'd8, 32'h0000_0006);
    vintr_i = 1'b0;
    rd_chk("R6 ext untouched", 4'd8, 32'h0000_00C3);
  endtask

  task automatic t_collide();
    step(1'b1, 1'b0, 1'b1, 4'd0, 32'h0000_0100);
    rd_chk("R10 write wins", 4'd0, 32'h0000_0100);
    step(1'b1, 1'b1, 1'b0, 4'd3, 32'h7777_0000);
    check("R10 read old", s_rdata, 32'h0000_3000);
    rd_chk("R10 read new", 4'd3, 32'h7777_0000);
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_store();
    t_pulses();
    t_msw();
    t_prio();
    t_collide();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule